// File: doc/BRIEF.md
# Unsigned Non-Restoring Array Divider

This block divides an unsigned 8-bit dividend by an unsigned 8-bit divisor. It returns an 8-bit quotient, an 8-bit remainder and two flags. Most divisions go through a non-restoring array. Each row of the array either adds or subtracts the divisor, choosing by the sign of the partial remainder from the row above. Each row gives one quotient bit, starting with the most significant. No row has a restore multiplexer. After the quotient rows comes one more adder row. It adds the divisor back to a negative final partial remainder, and a multiplexer then picks the corrected value or the uncorrected one.

The array rows cannot hold the full range of an 8-bit divisor, so divisors with the top bit set take a short side path instead. That path does a single trial subtraction and restores the dividend when the subtraction borrows. An output multiplexer, driven by the top divisor bit, chooses between the array result and the side-path result.

A request is the dividend and divisor presented with `start` high for one clock. The operands are registered into a first stage, the result is registered into the output stage, and `done` pulses two cycles after the request. One request is accepted every cycle. Results stay on the outputs until the next completion.

Top module: `nrd_divider`

## Requirements
- R1: For a nonzero divisor, the reported result satisfies dividend = quotient × divisor + remainder, with remainder < divisor.
- R2: `done` is high for exactly one cycle, two rising edges after each edge at which `start` is sampled high, whatever the operand values. Back-to-back requests each complete in turn, and `done` is never high without a matching request.
- R3: `div_zero` is 1 in a completion whose divisor was 0, and 0 in every other completion. Quotient and remainder carry no defined value after a zero-divisor completion.
- R4: `carry_out` is 0 at all times.
- R5: When divisor bit 7 is 1, the result is quotient 1 and remainder dividend − divisor if dividend ≥ divisor, and otherwise quotient 0 and remainder dividend.
- R6: A dividend smaller than a nonzero divisor gives quotient 0 and remainder equal to the dividend.
- R7: While reset is asserted and right after it is released, `done`, `quotient`, `remainder` and `div_zero` are all 0.
- R8: In a cycle without `done`, `quotient`, `remainder` and `div_zero` keep the values they had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe; operands are sampled with it |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 8 | Unsigned divisor |
| done | output | 1 | One-cycle pulse when a result is valid |
| quotient | output | 8 | Unsigned quotient |
| remainder | output | 8 | Unsigned remainder |
| div_zero | output | 1 | Set when the divisor was zero |
| carry_out | output | 1 | Carry flag, always cleared |

## Verification
On every cycle, the bound checker checks the two-cycle request-to-done relation in both directions. At each completion it checks the division identity and the remainder bound against the operands from two cycles earlier, and it checks the zero-divisor flag. It also checks that outputs hold between completions, that the carry flag is clear, and that the side path for large divisors yields a quotient of at most one. The bench sweeps every dividend–divisor pair back to back, which is the only way to exercise every add/subtract pattern and every remainder correction. Its gapped requests show the held outputs and the exact side-path and small-dividend values.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } rowop_e;

  localparam int unsigned PIPE_LAT = 2;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a ^ b));
  endfunction

endpackage

// File: rtl/nrd_row.sv
module nrd_row
  import nrd_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [N-1:0] acc,
  input  logic [N-1:0] dvs,
  input  rowop_e       op,
  output logic [N-1:0] sum
);
  logic         sub;
  logic [N-1:0] opnd;
  logic [N-1:0] cy;

  assign sub   = (op == OP_SUB);
  assign opnd  = dvs ^ {N{sub}};
  assign cy[0] = sub;

  for (genvar j = 0; j < N; j++) begin : g_bit
    assign sum[j] = fa_sum(acc[j], opnd[j], cy[j]);
    if (j < N - 1) begin : g_cy
      assign cy[j+1] = fa_carry(acc[j], opnd[j], cy[j]);
    end
  end
endmodule

// File: rtl/nrd_array.sv
module nrd_array
  import nrd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         neg_final
);
  localparam int PW = W + 1;

  logic [PW-1:0] prem [0:W];
  logic [W-1:0]  fixed;

  assign prem[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_row
    logic [PW-1:0] shifted;
    rowop_e        op;
    assign shifted = {prem[k][W-1:0], dividend[W-1-k]};
    assign op      = prem[k][W] ? OP_ADD : OP_SUB;
    nrd_row #(.N(PW)) u_row (
      .acc (shifted),
      .dvs ({1'b0, divisor}),
      .op  (op),
      .sum (prem[k+1])
    );
    assign quo[W-1-k] = ~prem[k+1][W];
  end

  nrd_row #(.N(W)) u_fix (
    .acc (prem[W][W-1:0]),
    .dvs (divisor),
    .op  (OP_ADD),
    .sum (fixed)
  );

  assign neg_final = prem[W][W];
  assign rem       = neg_final ? fixed : prem[W][W-1:0];
endmodule

// File: rtl/nrd_bigpath.sv
module nrd_bigpath
  import nrd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W:0] diff;
  logic       borrow;

  nrd_row #(.N(W + 1)) u_trial (
    .acc ({1'b0, dividend}),
    .dvs ({1'b0, divisor}),
    .op  (OP_SUB),
    .sum (diff)
  );

  assign borrow = diff[W];
  assign quo    = borrow ? '0 : W'(1);
  assign rem    = borrow ? dividend : diff[W-1:0];
endmodule

// File: rtl/nrd_divider.sv
module nrd_divider
  import nrd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero,
  output logic         carry_out
);
  logic         stage_valid;
  logic [W-1:0] st_a;
  logic [W-1:0] st_d;

  logic [W-1:0] arr_q, arr_r, big_q, big_r;
  logic         neg_final;
  logic         use_big;
  logic         dvs_zero;
  logic [W-1:0] sel_q, sel_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_valid <= 1'b0;
      st_a        <= '0;
      st_d        <= '0;
    end else begin
      stage_valid <= start;
      if (start) begin
        st_a <= dividend;
        st_d <= divisor;
      end
    end
  end

  nrd_array #(.W(W)) u_array (
    .dividend  (st_a),
    .divisor   (st_d),
    .quo       (arr_q),
    .rem       (arr_r),
    .neg_final (neg_final)
  );

  nrd_bigpath #(.W(W)) u_big (
    .dividend (st_a),
    .divisor  (st_d),
    .quo      (big_q),
    .rem      (big_r)
  );

  assign use_big  = st_d[W-1];
  assign dvs_zero = (st_d == '0);
  assign sel_q    = use_big ? big_q : arr_q;
  assign sel_r    = use_big ? big_r : arr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= stage_valid;
      if (stage_valid) begin
        quotient  <= sel_q;
        remainder <= sel_r;
        div_zero  <= dvs_zero;
      end
    end
  end

  assign carry_out = 1'b0;
endmodule

// File: rtl/nrd_divider_chk.sv
module nrd_divider_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_zero,
  input logic         carry_out,
  input logic         stage_valid,
  input logic         use_big,
  input logic         neg_final
);
  localparam int W2 = 2 * W;

  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 done);

  a_r2_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |->
      (({{W{1'b0}}, quotient} * {{W{1'b0}}, $past(divisor, 2)}
        + {{W{1'b0}}, remainder}) == W2'({{W{1'b0}}, $past(dividend, 2)})));

  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < $past(divisor, 2)));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_zero == ($past(divisor, 2) == '0)));

  a_r4_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == 1'b0);

  a_r5_big_path: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_valid && use_big) |=> (done && quotient <= W'(1)));

  a_r1_fix_only_small: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_valid && !use_big && neg_final) |=> (done && !div_zero));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));
endmodule

bind nrd_divider nrd_divider_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .dividend    (dividend),
  .divisor     (divisor),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_zero    (div_zero),
  .carry_out   (carry_out),
  .stage_valid (stage_valid),
  .use_big     (use_big),
  .neg_final   (neg_final)
);

// File: tb/sim_nrd_divider.sv
module sim_nrd_divider;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dvd = '0;
  logic [7:0] dvs = '0;
  logic       done;
  logic [7:0] quotient;
  logic [7:0] remainder;
  logic       div_zero;
  logic       carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  bit       h_v [0:1];
  bit [7:0] h_a [0:1];
  bit [7:0] h_b [0:1];
  bit       known = 1'b1;
  bit [7:0] exp_q = '0;
  bit [7:0] exp_r = '0;
  bit       exp_z = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  nrd_divider #(.W(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dvd),
    .divisor   (dvs),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero),
    .carry_out (carry_out)
  );

  task automatic fail_msg(input string req, input string what,
                          input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic check_slot();
    n_checks++;
    if (carry_out !== 1'b0) fail_msg("R4", "carry_out", carry_out, 0);
    if (h_v[1]) begin
      n_checks++;
      if (done !== 1'b1) fail_msg("R2", "done", done, 1);
      if (h_b[1] == 0) begin
        n_checks++;
        if (div_zero !== 1'b1) fail_msg("R3", "div_zero", div_zero, 1);
        known = 1'b0;
        exp_z = 1'b1;
      end else begin
        string tag;
        bit [7:0] eq, er;
        eq = h_a[1] / h_b[1];
        er = h_a[1] % h_b[1];
        if (h_b[1][7]) tag = "R5";
        else if (h_a[1] < h_b[1]) tag = "R6";
        else tag = "R1";
        n_checks++;
        if (quotient !== eq) fail_msg(tag, "quotient", quotient, eq);
        n_checks++;
        if (remainder !== er) fail_msg(tag, "remainder", remainder, er);
        n_checks++;
        if (div_zero !== 1'b0) fail_msg("R3", "div_zero", div_zero, 0);
        known = 1'b1;
        exp_q = eq;
        exp_r = er;
        exp_z = 1'b0;
      end
    end else begin
      n_checks++;
      if (done !== 1'b0) fail_msg("R2", "done", done, 0);
      n_checks++;
      if (div_zero !== exp_z) fail_msg("R8", "div_zero held", div_zero, exp_z);
      if (known) begin
        n_checks++;
        if (quotient !== exp_q) fail_msg("R8", "quotient held", quotient, exp_q);
        n_checks++;
        if (remainder !== exp_r) fail_msg("R8", "remainder held", remainder, exp_r);
      end
    end
  endtask

  task automatic step(input bit st, input bit [7:0] a, input bit [7:0] b);
    @(negedge clk);
    check_slot();
    h_v[1] = h_v[0];
    h_a[1] = h_a[0];
    h_b[1] = h_b[0];
    h_v[0] = st;
    h_a[0] = a;
    h_b[0] = b;
    start  = st;
    dvd    = a;
    dvs    = b;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    h_v[0] = 1'b0; h_v[1] = 1'b0;
    h_a[0] = '0;   h_a[1] = '0;
    h_b[0] = '0;   h_b[1] = '0;
    repeat (3) @(negedge clk);
    // R7: state while reset is asserted
    n_checks++;
    if (done !== 1'b0 || quotient !== 8'd0 || remainder !== 8'd0 || div_zero !== 1'b0)
      fail_msg("R7", "outputs in reset", {done, div_zero, quotient, remainder}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: state just after release
    n_checks++;
    if (done !== 1'b0 || quotient !== 8'd0 || remainder !== 8'd0 || div_zero !== 1'b0)
      fail_msg("R7", "outputs after reset", {done, div_zero, quotient, remainder}, 0);

    // Exhaustive back-to-back sweep (R1, R2, R3, R5, R6)
    for (int b = 0; b < 256; b++) begin
      for (int a = 0; a < 256; a++) begin
        step(1'b1, 8'(a), 8'(b));
      end
    end

    // Gapped requests: holding (R8), side path (R5), small dividend (R6)
    step(1'b1, 8'd200, 8'd7);
    for (int i = 0; i < 4; i++) step(1'b0, 8'd55, 8'd3);
    step(1'b1, 8'd9, 8'd0);
    for (int i = 0; i < 3; i++) step(1'b0, 8'd1, 8'd1);
    step(1'b1, 8'd255, 8'd128);
    for (int i = 0; i < 3; i++) step(1'b0, 8'd0, 8'd0);
    step(1'b1, 8'd100, 8'd200);
    for (int i = 0; i < 3; i++) step(1'b0, 8'd0, 8'd0);
    step(1'b1, 8'd127, 8'd127);
    step(1'b1, 8'd128, 8'd255);
    for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 8'd0);

    finish_run();
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule